// File: doc/BRIEF.md
# Monitor Setup Byte Stream Loader

This block sits behind a serial bus interface and turns the data bytes that follow a monitor-mode setup command into configuration state. The first byte of a command carries one alarm-clear request per channel, a 3-bit scan-delay code and an interrupt enable. After it come threshold records, three bytes each. Every record holds a 10-bit lower threshold followed by a 10-bit upper threshold.

The number of records is not fixed. It follows a highest-channel setting and a differential-mode flag, and both are sampled with the first byte. In single-ended mode one record is expected for each channel from 0 up to the highest channel. In differential mode only the even channels get a record, and each such record loads both channels of its pair.

A record is committed only when its third byte arrives. A stop in the middle of a record therefore leaves that channel's thresholds as they were. Every byte accepted inside a command is acknowledged one cycle later, including surplus bytes that have no effect.

Top module: `msl_setup_loader`

## Requirements
- R1: On a start byte (`byte_vld` and `cmd_start` high together), `delay_code` takes data bits 3..1 (bit 3 is the MSB) and `irq_en` takes data bit 0, both visible the cycle after. They hold their value until the next start byte.
- R2: On a start byte, `alarm_clr[i]` pulses high for exactly one cycle, the cycle after, when data bit (7-i) is 1. A bit that is 0 produces no pulse, and `alarm_clr` is zero in every other cycle.
- R3: A record is three bytes. Lower threshold bits 9..4 are byte0[5:0] and bits 3..0 are byte1[7:4]. Upper threshold bits 9..8 are byte1[1:0] and bits 7..0 are byte2[7:0]. byte0[7:6] and byte1[3:2] are ignored. Both thresholds of the target channel update together, the cycle after byte2, and at no other time.
- R4: In single-ended mode (`diff_mode`=0), hi_chan+1 records are expected, and record k loads channel k.
- R5: In differential mode, floor(hi_chan/2)+1 records are expected. Record k loads channels 2k and 2k+1 with identical values.
- R6: `cmd_stop` ends the command. A record left incomplete is discarded, and channels whose record did not finish keep their previous thresholds.
- R7: Bytes after the last expected record are acknowledged but change no output.
- R8: `byte_ack` is high for one cycle, the cycle after each accepted byte. A byte is accepted if it is a start byte, or if it arrives inside a command without `cmd_stop`. A byte outside a command, or one that coincides with `cmd_stop` and carries no start, is neither acknowledged nor used.
- R9: After reset, every lower threshold is 0, every upper threshold is 1023, `delay_code` and `irq_en` are 0, and `byte_ack` and `alarm_clr` are low.
- R10: `hi_chan` and `diff_mode` are sampled only on a start byte. Changes to them during a command do not alter it.
- R11: A start byte inside a running command restarts the command at the first byte. A start byte has priority over a `cmd_stop` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| cmd_start | input | 1 | Qualifies the current byte as the first byte of a command |
| cmd_stop | input | 1 | Ends the current command |
| hi_chan | input | 2 | Highest channel with a record |
| diff_mode | input | 1 | Channel pairs share records |
| byte_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| alarm_clr | output | 4 | One-cycle alarm-clear pulses, one bit per channel |
| delay_code | output | 3 | Scan-delay code |
| irq_en | output | 1 | Interrupt enable |
| lo_thr | output | 40 | Lower thresholds, channel c at bits [10c+9:10c] |
| up_thr | output | 40 | Upper thresholds, channel c at bits [10c+9:10c] |

## Verification
The bench builds the block with its default of four channels. With that setting all four highest-channel values can be tried in both modes, so every record count from one to four is reached, along with pair writes to both halves of the bank. The behavioural model works from the number of bytes counted since the start byte, not from a state machine. This lets the bench catch miscounted record totals, odd-channel placeholders in differential mode, partial-record commits after a stop, and effects from surplus bytes. The stimulus sets the don't-care bits in each record to nonzero values, so any leak from them into the thresholds shows up.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int THR_W     = 10;
  localparam int BYTE_W    = 8;
  localparam int DLY_W     = 3;
  localparam int CLR_TOP   = 7;   // bit of channel 0 alarm clear; channel i at 7-i
  localparam int DLY_MSB   = 3;
  localparam int DLY_LSB   = 1;
  localparam int IEN_BIT   = 0;
  localparam int LO_HI_W   = 6;   // lower bits 9..4 in record byte 0
  localparam int LO_LO_W   = 4;   // lower bits 3..0 in record byte 1
  localparam int UP_HI_W   = 2;   // upper bits 9..8 in record byte 1

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_B0,
    ST_B1,
    ST_B2,
    ST_OVER
  } ld_state_e;

  // number of records a command carries
  function automatic int unsigned rec_total(input int unsigned hi, input logic diff);
    return diff ? (hi / 2) + 1 : hi + 1;
  endfunction

  // first channel loaded by record idx
  function automatic int unsigned rec_chan(input int unsigned idx, input logic diff);
    return diff ? idx * 2 : idx;
  endfunction

  function automatic logic [THR_W-1:0] lo_join(input logic [LO_HI_W-1:0] hi6,
                                               input logic [LO_LO_W-1:0] lo4);
    return {hi6, lo4};
  endfunction

  function automatic logic [THR_W-1:0] up_join(input logic [UP_HI_W-1:0] hi2,
                                               input logic [BYTE_W-1:0] lo8);
    return {hi2, lo8};
  endfunction
endpackage

// File: rtl/msl_seq.sv
module msl_seq
  import msl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHSEL_W = $clog2(NUM_CH),
  localparam int CNT_W = CHSEL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_vld,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic [CHSEL_W-1:0] hi_chan,
  input  logic               diff_mode,
  output logic               ev_cfg,
  output logic               ev_b0,
  output logic               ev_b1,
  output logic               ev_b2,
  output logic               ev_ign,
  output logic [CHSEL_W-1:0] tgt_ch,
  output logic               pair_wr,
  output logic               byte_ack
);
  ld_state_e          st;
  logic [CHSEL_W-1:0] rec_idx;
  logic [CHSEL_W-1:0] hi_l;
  logic               diff_l;
  logic [CNT_W-1:0]   recs_exp;
  logic               last_rec;
  logic               rec_byte;
  logic               accept;

  assign recs_exp = CNT_W'(rec_total(32'(hi_l), diff_l));
  assign last_rec = (({1'b0, rec_idx} + CNT_W'(1)) == recs_exp);
  assign tgt_ch   = CHSEL_W'(rec_chan(32'(rec_idx), diff_l));
  assign pair_wr  = diff_l;

  // a byte that belongs to the running command
  assign rec_byte = byte_vld && !cmd_start && !cmd_stop;
  assign ev_cfg   = byte_vld && cmd_start;
  assign ev_b0    = rec_byte && (st == ST_B0);
  assign ev_b1    = rec_byte && (st == ST_B1);
  assign ev_b2    = rec_byte && (st == ST_B2);
  assign ev_ign   = rec_byte && (st == ST_OVER);
  assign accept   = ev_cfg || ev_b0 || ev_b1 || ev_b2 || ev_ign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rec_idx  <= '0;
      hi_l     <= '0;
      diff_l   <= 1'b0;
      byte_ack <= 1'b0;
    end else begin
      byte_ack <= accept;
      if (ev_cfg) begin
        st      <= ST_B0;
        rec_idx <= '0;
        hi_l    <= hi_chan;
        diff_l  <= diff_mode;
      end else if (cmd_stop) begin
        st <= ST_IDLE;
      end else if (byte_vld) begin
        unique case (st)
          ST_B0: st <= ST_B1;
          ST_B1: st <= ST_B2;
          ST_B2: begin
            if (last_rec) begin
              st <= ST_OVER;
            end else begin
              st      <= ST_B0;
              rec_idx <= rec_idx + CHSEL_W'(1);
            end
          end
          default: st <= st;
        endcase
      end
    end
  end

  // R8
  ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> $past(byte_vld));

  // R4
  rec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B0 || st == ST_B1 || st == ST_B2) |-> ({1'b0, rec_idx} < recs_exp));

  // R5
  pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_b2 && pair_wr) |-> (tgt_ch[0] == 1'b0));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cfg |=> ($stable(hi_l) && $stable(diff_l)));

  // R7
  over_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OVER && !cmd_start && !cmd_stop) |=> (st == ST_OVER));
endmodule

// File: rtl/msl_cfg_reg.sv
module msl_cfg_reg
  import msl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cfg,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [NUM_CH-1:0] alarm_clr,
  output logic [DLY_W-1:0]  delay_code,
  output logic              irq_en
);
  logic [NUM_CH-1:0] clr_bits;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    assign clr_bits[i] = byte_data[CLR_TOP - i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_clr  <= '0;
      delay_code <= '0;
      irq_en     <= 1'b0;
    end else begin
      alarm_clr <= ev_cfg ? clr_bits : '0;
      if (ev_cfg) begin
        delay_code <= byte_data[DLY_MSB:DLY_LSB];
        irq_en     <= byte_data[IEN_BIT];
      end
    end
  end

  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|alarm_clr) |-> $past(ev_cfg));

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cfg |=> ($stable(delay_code) && $stable(irq_en)));
endmodule

// File: rtl/msl_thr_bank.sv
module msl_thr_bank
  import msl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHSEL_W = $clog2(NUM_CH),
  localparam int BANK_W = NUM_CH * THR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               ev_b0,
  input  logic               ev_b1,
  input  logic               ev_b2,
  input  logic [CHSEL_W-1:0] tgt_ch,
  input  logic               pair_wr,
  output logic [BANK_W-1:0]  lo_thr,
  output logic [BANK_W-1:0]  up_thr
);
  logic [LO_HI_W-1:0] stg_lo_hi;
  logic [LO_LO_W-1:0] stg_lo_lo;
  logic [UP_HI_W-1:0] stg_up_hi;
  logic [THR_W-1:0]   new_lo;
  logic [THR_W-1:0]   new_up;
  logic [CHSEL_W-1:0] mate_ch;

  assign new_lo  = lo_join(stg_lo_hi, stg_lo_lo);
  assign new_up  = up_join(stg_up_hi, byte_data);
  assign mate_ch = tgt_ch | CHSEL_W'(1);

  // partial record bytes wait here until the record is whole
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lo_hi <= '0;
      stg_lo_lo <= '0;
      stg_up_hi <= '0;
    end else begin
      if (ev_b0) stg_lo_hi <= byte_data[LO_HI_W-1:0];
      if (ev_b1) begin
        stg_lo_lo <= byte_data[BYTE_W-1 -: LO_LO_W];
        stg_up_hi <= byte_data[UP_HI_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_en;
    assign wr_en = ev_b2 && ((tgt_ch == CHSEL_W'(c)) ||
                             (pair_wr && (mate_ch == CHSEL_W'(c))));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_thr[c*THR_W +: THR_W] <= '0;
        up_thr[c*THR_W +: THR_W] <= '1;
      end else if (wr_en) begin
        lo_thr[c*THR_W +: THR_W] <= new_lo;
        up_thr[c*THR_W +: THR_W] <= new_up;
      end
    end
  end

  // R3
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_b2 |=> ($stable(lo_thr) && $stable(up_thr)));

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_b0 |=> $stable(stg_lo_hi));
endmodule

// File: rtl/msl_setup_loader.sv
module msl_setup_loader
  import msl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHSEL_W = $clog2(NUM_CH),
  localparam int BANK_W = NUM_CH * THR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_vld,
  input  logic [7:0]         byte_data,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic [CHSEL_W-1:0] hi_chan,
  input  logic               diff_mode,
  output logic               byte_ack,
  output logic [NUM_CH-1:0]  alarm_clr,
  output logic [2:0]         delay_code,
  output logic               irq_en,
  output logic [BANK_W-1:0]  lo_thr,
  output logic [BANK_W-1:0]  up_thr
);
  logic               ev_cfg;
  logic               ev_b0;
  logic               ev_b1;
  logic               ev_b2;
  logic               ev_ign;
  logic [CHSEL_W-1:0] tgt_ch;
  logic               pair_wr;

  msl_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .hi_chan   (hi_chan),
    .diff_mode (diff_mode),
    .ev_cfg    (ev_cfg),
    .ev_b0     (ev_b0),
    .ev_b1     (ev_b1),
    .ev_b2     (ev_b2),
    .ev_ign    (ev_ign),
    .tgt_ch    (tgt_ch),
    .pair_wr   (pair_wr),
    .byte_ack  (byte_ack)
  );

  msl_cfg_reg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_cfg     (ev_cfg),
    .byte_data  (byte_data),
    .alarm_clr  (alarm_clr),
    .delay_code (delay_code),
    .irq_en     (irq_en)
  );

  msl_thr_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_data (byte_data),
    .ev_b0     (ev_b0),
    .ev_b1     (ev_b1),
    .ev_b2     (ev_b2),
    .tgt_ch    (tgt_ch),
    .pair_wr   (pair_wr),
    .lo_thr    (lo_thr),
    .up_thr    (up_thr)
  );

  // R7
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ign |=> ($stable(lo_thr) && $stable(up_thr) && (alarm_clr == '0) &&
                $stable(delay_code) && $stable(irq_en) && byte_ack));
endmodule

// File: tb/msl_setup_loader_tb.sv
module msl_setup_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       cmd_start = 1'b0;
  logic       cmd_stop = 1'b0;
  logic [1:0] hi_chan = '0;
  logic       diff_mode = 1'b0;
  logic       byte_ack;
  logic [3:0] alarm_clr;
  logic [2:0] delay_code;
  logic       irq_en;
  logic [39:0] lo_thr;
  logic [39:0] up_thr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string tag = "R9";

  always #2.5 clk = ~clk;

  msl_setup_loader u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .hi_chan(hi_chan),
    .diff_mode(diff_mode), .byte_ack(byte_ack), .alarm_clr(alarm_clr),
    .delay_code(delay_code), .irq_en(irq_en), .lo_thr(lo_thr), .up_thr(up_thr)
  );

  // behavioural reference: byte count since start
  bit         m_act;
  int         m_n;
  int         m_exp;
  bit         m_diff;
  int         m_rec;
  int         m_pos;
  int         m_ch;
  int         m_stage[3];
  int         m_lo[4];
  int         m_up[4];
  bit         m_ack;
  int         m_clr;
  int         m_dly;
  bit         m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_n = 0; m_exp = 0; m_diff = 0;
      m_ack = 0; m_clr = 0; m_dly = 0; m_irq = 0;
      for (int i = 0; i < 4; i++) begin m_lo[i] = 0; m_up[i] = 1023; end
    end else begin
      m_ack = 0;
      m_clr = 0;
      if (byte_vld && cmd_start) begin
        m_act = 1; m_n = 0;
        m_diff = diff_mode;
        m_exp = diff_mode ? (int'(hi_chan) / 2 + 1) : (int'(hi_chan) + 1);
        m_ack = 1;
        m_dly = (int'(byte_data) >> 1) % 8;
        m_irq = byte_data[0];
        for (int i = 0; i < 4; i++)
          if (byte_data[7-i]) m_clr = m_clr + (1 << i);
      end else if (cmd_stop) begin
        m_act = 0;
      end else if (byte_vld && m_act) begin
        m_ack = 1;
        if (m_n < 3 * m_exp) begin
          m_rec = m_n / 3;
          m_pos = m_n % 3;
          m_stage[m_pos] = int'(byte_data);
          if (m_pos == 2) begin
            m_ch = m_diff ? 2 * m_rec : m_rec;
            m_lo[m_ch] = (m_stage[0] % 64) * 16 + m_stage[1] / 16;
            m_up[m_ch] = (m_stage[1] % 4) * 256 + m_stage[2];
            if (m_diff) begin
              m_lo[m_ch+1] = m_lo[m_ch];
              m_up[m_ch+1] = m_up[m_ch];
            end
          end
        end
        m_n++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({"R8 ack ", tag}, int'(byte_ack), int'(m_ack));
      chk({"R2 clr ", tag}, int'(alarm_clr), m_clr);
      chk({"R1 delay ", tag}, int'(delay_code), m_dly);
      chk({"R1 irq ", tag}, int'(irq_en), int'(m_irq));
      for (int c = 0; c < 4; c++) begin
        chk({"R3 lo ", tag}, int'(lo_thr[c*10 +: 10]), m_lo[c]);
        chk({"R3 up ", tag}, int'(up_thr[c*10 +: 10]), m_up[c]);
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit st);
    byte_vld = 1'b1; byte_data = d; cmd_start = st;
    @(negedge clk);
    byte_vld = 1'b0; byte_data = '0; cmd_start = 1'b0;
  endtask

  task automatic stop();
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  // don't-care bits are driven as ones to prove they are ignored
  task automatic record(input int lo, input int up);
    send({2'b11, 6'(lo >> 4)}, 0);
    send({4'(lo), 2'b11, 2'(up >> 8)}, 0);
    send(8'(up), 0);
  endtask

  function automatic int lo_of(input int c);
    return int'(lo_thr[c*10 +: 10]);
  endfunction

  function automatic int up_of(input int c);
    return int'(up_thr[c*10 +: 10]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int c = 0; c < 4; c++) begin
      chk("R9 lo reset", lo_of(c), 0);
      chk("R9 up reset", up_of(c), 1023);
    end
    chk("R9 ack reset", int'(byte_ack), 0);
    chk("R9 cfg reset", int'({alarm_clr, delay_code, irq_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R8 idle";
    send(8'hFF, 0);
    send(8'h3C, 0);
    @(negedge clk);

    tag = "R4 single hi3";
    hi_chan = 2'd3; diff_mode = 1'b0;
    send(8'hA5, 1);
    record(10'h155, 10'h2AA);
    record(10'h001, 10'h3FE);
    record(10'h210, 10'h0F3);
    record(10'h3FF, 10'h000);
    @(negedge clk);
    chk("R4 ch3 lo", lo_of(3), 10'h3FF);
    chk("R4 ch0 up", up_of(0), 10'h2AA);
    stop();

    tag = "R7 single hi1 extra";
    hi_chan = 2'd1;
    send(8'h5E, 1);
    record(10'h0AB, 10'h1CD);
    record(10'h123, 10'h321);
    send(8'hFF, 0);
    send(8'h00, 0);
    send(8'h77, 0);
    chk("R7 ch2 kept", lo_of(2), 10'h210);
    stop();

    tag = "R5 diff hi3 R10";
    hi_chan = 2'd3; diff_mode = 1'b1;
    send(8'h1B, 1);
    hi_chan = 2'd0; diff_mode = 1'b0;
    record(10'h2C4, 10'h301);
    record(10'h04F, 10'h3A0);
    @(negedge clk);
    chk("R5 pair1 lo", lo_of(1), 10'h2C4);
    chk("R5 pair3 up", up_of(3), 10'h3A0);
    chk("R10 ch2 diff", lo_of(2), 10'h04F);
    stop();

    tag = "R5 diff hi0";
    hi_chan = 2'd0; diff_mode = 1'b1;
    send(8'hF0, 1);
    record(10'h111, 10'h222);
    send(8'h3F, 0);
    send(8'hFF, 0);
    send(8'hFF, 0);
    chk("R5 ch2 untouched", lo_of(2), 10'h04F);
    stop();

    tag = "R6 partial";
    hi_chan = 2'd2; diff_mode = 1'b0;
    send(8'h00, 1);
    record(10'h155, 10'h055);
    send(8'h2A, 0);
    send(8'hF3, 0);
    stop();
    send(8'hEE, 0);
    @(negedge clk);
    chk("R6 ch1 kept lo", lo_of(1), 10'h111);
    chk("R6 ch0 new", lo_of(0), 10'h155);

    tag = "R11 restart";
    hi_chan = 2'd1; diff_mode = 1'b0;
    send(8'h81, 1);
    send(8'h12, 0);
    send(8'h34, 0);
    send(8'h42, 1);
    record(10'h3C3, 10'h0C0);
    // start wins over stop in the same cycle
    cmd_stop = 1'b1;
    send(8'h10, 1);
    cmd_stop = 1'b0;
    chk("R11 start over stop", int'(delay_code), 0);
    // stop with a byte: not acknowledged
    tag = "R8 stop with byte";
    cmd_stop = 1'b1;
    send(8'h99, 0);
    cmd_stop = 1'b0;
    chk("R8 stop byte ack", int'(byte_ack), 0);
    send(8'h99, 0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule